// File: doc/BRIEF.md
# Bitwise Truth-Table Logic Unit

This execution unit evaluates arbitrary bitwise Boolean functions across a 64-bit general-purpose register datapath. Two operations are offered. The ternary operation treats every bit position as three inputs: the old destination value, the first source and the second source. It looks up the output bit in an 8-entry truth table supplied as an immediate, so the destination is both read and rewritten. The binary operation treats every bit position as two inputs, the first and second sources. It takes its 4-entry truth table at run time from a nibble of a third register, and a half-select input picks which nibble.

The operand values arrive already read from the register file, together with a valid strobe. One clock later the unit presents the result with a single-cycle valid pulse. When the ternary operation is issued with its record flag set, the unit also produces a condition-field update. That update holds less-than, greater-than and equal, taken from a signed comparison of the result with zero, plus a copy of the summary-overflow input.

Top module: `lut_logic_unit`

## Requirements
- R1: For the ternary operation (`op_sel`=0), result bit i equals bit j of `tbl_imm`, where j = 4*`rt_val`[i] + 2*`ra_val`[i] + `rb_val`[i], and table bit j is the bit of weight 2^j. Bit 0 of every vector is its least significant bit.
- R2: For the ternary operation with `tbl_imm` = 8'hD8, the result equals `ra_val` where `rb_val` is 1 and `rt_val` where `rb_val` is 0.
- R3: For the binary operation (`op_sel`=1), the 4-bit table is `rc_val`[3:0] when `nh`=0 and `rc_val`[7:4] when `nh`=1. Result bit i equals table bit (2*`ra_val`[i] + `rb_val`[i]).
- R4: The binary operation's result does not depend on `rt_val`, `tbl_imm`, `rec` or `rc_val`[63:8].
- R5: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise. `result` carries that operation's value in that cycle.
- R6: When `in_valid` is low, `result` keeps its previous value in the next cycle.
- R7: A ternary operation issued with `rec`=1 raises `cr0_we` together with its `out_valid`. It drives `cr0` = {LT, GT, EQ, SO} (bit 3 down to bit 0): LT = result negative as a signed 64-bit value, GT = result positive, EQ = result zero, SO = `so_in` sampled with the operation.
- R8: A ternary operation with `rec`=0, any binary operation and any idle cycle leave `cr0_we` low and `cr0` at 4'b0000 in the following cycle.
- R9: While `rst_n` is low, `out_valid`, `cr0_we`, `cr0` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | 0 = ternary immediate table, 1 = binary register table |
| rt_val | input | 64 | Old destination value (ternary input, most significant index bit) |
| ra_val | input | 64 | First source |
| rb_val | input | 64 | Second source |
| rc_val | input | 64 | Table register for the binary operation |
| tbl_imm | input | 8 | Immediate truth table for the ternary operation |
| nh | input | 1 | Nibble select for the binary table |
| rec | input | 1 | Record flag: request condition-field update |
| so_in | input | 1 | Summary-overflow bit copied into the update |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Registered result |
| cr0_we | output | 1 | Condition-field write enable |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench sweeps all 256 immediate tables with random operands. A unit that reversed the index order, for example by taking the old destination as the least significant index bit, would fail on most asymmetric tables, including the multiplexer table 8'hD8, which would return the wrong operand. Binary operations alternate the nibble select and vary the destination, the immediate and the upper table-register bits. A unit that chose the wrong nibble, or let the ternary inputs leak into the binary path, would return a different result. Records are forced onto zero, negative and positive results with the overflow input toggled, so a sign test of the wrong bit or an unsigned comparison shows up in the flags. Idle gaps and back-to-back strobes check that the result holds and that write enables never appear for binary or unrecorded operations.

// File: rtl/lut_logic_pkg.sv
// Package: shared types for the bitwise truth-table logic unit.
// Assumes bit 0 of every data vector is the least significant bit.
package lut_logic_pkg;

    // Operation select encoding.
    typedef enum logic {
        OP_TERN = 1'b0,
        OP_BIN  = 1'b1
    } lut_op_e;

    // Condition field layout, most significant first.
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_field_t;

    localparam int TERN_TBL_W = 8;
    localparam int BIN_TBL_W  = 4;
    localparam int BIN_HALVES = 2;

endpackage

// File: rtl/lut_tern_array.sv
// Module: lut_tern_array
// Per-bit three-input lookup. Each result bit picks one of the eight
// table bits, indexed by {old destination, first source, second source}.
// Purely combinational; assumes the table is TBL_W = 8 bits wide.
module lut_tern_array #(
    parameter int WIDTH = 64,
    parameter int TBL_W = 8
) (
    input  logic [WIDTH-1:0] rt_i,
    input  logic [WIDTH-1:0] ra_i,
    input  logic [WIDTH-1:0] rb_i,
    input  logic [TBL_W-1:0] tbl_i,
    output logic [WIDTH-1:0] res_o
);
    localparam int IDX_W = $clog2(TBL_W);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [IDX_W-1:0] idx;
        // Form the three-bit table index for this bit position.
        always_comb idx = {rt_i[g], ra_i[g], rb_i[g]};
        // Select the table entry.
        always_comb res_o[g] = tbl_i[idx];
    end

endmodule

// File: rtl/lut_bin_array.sv
// Module: lut_bin_array
// Per-bit two-input lookup whose 4-bit table is one nibble of a
// register value. The nibble is chosen by a half-select; the source
// window is the low HALVES*TBL_W bits of that register.
// Purely combinational.
module lut_bin_array #(
    parameter int WIDTH  = 64,
    parameter int TBL_W  = 4,
    parameter int HALVES = 2
) (
    input  logic [WIDTH-1:0]        ra_i,
    input  logic [WIDTH-1:0]        rb_i,
    input  logic [HALVES*TBL_W-1:0] tbl_src_i,
    input  logic [$clog2(HALVES)-1:0] half_i,
    output logic [WIDTH-1:0]        res_o
);
    localparam int IDX_W = $clog2(TBL_W);

    logic [TBL_W-1:0] nib [HALVES];
    logic [TBL_W-1:0] tbl;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        // Slice out each candidate nibble.
        always_comb nib[h] = tbl_src_i[h*TBL_W +: TBL_W];
    end

    // Choose the active table nibble.
    always_comb tbl = nib[half_i];

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [IDX_W-1:0] idx;
        // Form the two-bit index for this bit position.
        always_comb idx = {ra_i[g], rb_i[g]};
        // Select the table entry.
        always_comb res_o[g] = tbl[idx];
    end

endmodule

// File: rtl/lut_cr_flags.sv
// Module: lut_cr_flags
// Derives the condition field from a result: signed compare with zero
// plus a pass-through summary-overflow bit. Combinational.
module lut_cr_flags
    import lut_logic_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             so_i,
    output cr_field_t        flags_o
);
    logic is_zero;

    // Zero detect over the whole word.
    always_comb is_zero = (val_i == '0);

    // Assemble the flags from sign and zero detect.
    always_comb begin
        flags_o.lt = val_i[WIDTH-1];
        flags_o.gt = !val_i[WIDTH-1] && !is_zero;
        flags_o.eq = is_zero;
        flags_o.so = so_i;
    end

endmodule

// File: rtl/lut_logic_unit.sv
// Module: lut_logic_unit (top)
// Bitwise truth-table execution unit. The ternary form looks up an
// 8-bit immediate table with {old RT, RA, RB}; the binary form looks up
// a nibble of RC with {RA, RB}. The result and the optional condition
// field update are registered one cycle after the strobe.
// Assumes operands are presented already read and stable with in_valid.
module lut_logic_unit
    import lut_logic_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             op_sel,
    input  logic [WIDTH-1:0] rt_val,
    input  logic [WIDTH-1:0] ra_val,
    input  logic [WIDTH-1:0] rb_val,
    input  logic [WIDTH-1:0] rc_val,
    input  logic [7:0]       tbl_imm,
    input  logic             nh,
    input  logic             rec,
    input  logic             so_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             cr0_we,
    output logic [3:0]       cr0
);
    localparam int SRC_W = BIN_HALVES * BIN_TBL_W;

    lut_op_e          op;
    logic [WIDTH-1:0] tern_res;
    logic [WIDTH-1:0] bin_res;
    logic [WIDTH-1:0] next_res;
    cr_field_t        next_flags;
    logic             do_record;
    logic             unused_rc_hi;

    // Decode the operation select.
    always_comb op = lut_op_e'(op_sel);

    // Table register bits above the two nibbles play no part.
    always_comb unused_rc_hi = ^rc_val[WIDTH-1:SRC_W];

    lut_tern_array #(
        .WIDTH (WIDTH),
        .TBL_W (TERN_TBL_W)
    ) u_tern (
        .rt_i  (rt_val),
        .ra_i  (ra_val),
        .rb_i  (rb_val),
        .tbl_i (tbl_imm),
        .res_o (tern_res)
    );

    lut_bin_array #(
        .WIDTH  (WIDTH),
        .TBL_W  (BIN_TBL_W),
        .HALVES (BIN_HALVES)
    ) u_bin (
        .ra_i      (ra_val),
        .rb_i      (rb_val),
        .tbl_src_i (rc_val[SRC_W-1:0]),
        .half_i    (nh),
        .res_o     (bin_res)
    );

    // Pick the result of the selected operation.
    always_comb next_res = (op == OP_TERN) ? tern_res : bin_res;

    lut_cr_flags #(
        .WIDTH (WIDTH)
    ) u_flags (
        .val_i   (tern_res),
        .so_i    (so_in),
        .flags_o (next_flags)
    );

    // Only a recorded ternary operation updates the condition field.
    always_comb do_record = in_valid && (op == OP_TERN) && rec;

    // Result register: loads on a strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid) begin
            result <= next_res;
        end
    end

    // Valid and condition-field registers: one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cr0_we    <= 1'b0;
            cr0       <= '0;
        end else begin
            out_valid <= in_valid;
            cr0_we    <= do_record;
            cr0       <= do_record ? next_flags : '0;
        end
    end

endmodule

// File: rtl/lut_logic_unit_chk.sv
// Module: lut_logic_unit_chk
// Property checker for lut_logic_unit, attached with bind below.
module lut_logic_unit_chk #(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             op_sel,
    input logic             rec,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             cr0_we,
    input logic [3:0]       cr0
);

    p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_record_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && rec) |=> (cr0_we && out_valid));

    p_eq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |-> (cr0[1] == (result == '0)));

    p_lt_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |-> (cr0[3] == result[WIDTH-1]));

    p_one_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |-> ($countones(cr0[3:1]) == 1));

    p_no_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !op_sel && rec) |=> !cr0_we);

    p_cr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cr0_we |-> (cr0 == 4'b0000));

endmodule

bind lut_logic_unit lut_logic_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .rec       (rec),
    .out_valid (out_valid),
    .result    (result),
    .cr0_we    (cr0_we),
    .cr0       (cr0)
);

// File: tb/lut_logic_unit_test.sv
`timescale 1ns/1ps
module lut_logic_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic [63:0] rt_val = '0, ra_val = '0, rb_val = '0, rc_val = '0;
    logic [7:0]  tbl_imm = '0;
    logic        nh = 1'b0, rec = 1'b0, so_in = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        cr0_we;
    logic [3:0]  cr0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Behavioural model state: what the outputs should show next.
    bit          m_valid = 0;
    logic [63:0] m_result = '0;
    bit          m_we = 0;
    logic [3:0]  m_cr0 = '0;
    string       m_tag = "R9";

    always #2 clk = ~clk;

    lut_logic_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .rt_val(rt_val), .ra_val(ra_val), .rb_val(rb_val), .rc_val(rc_val),
        .tbl_imm(tbl_imm), .nh(nh), .rec(rec), .so_in(so_in),
        .out_valid(out_valid), .result(result), .cr0_we(cr0_we), .cr0(cr0)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_tern(logic [63:0] t, logic [63:0] a,
                                             logic [63:0] b, logic [7:0] tb);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            int j;
            j = (t[i] ? 4 : 0) + (a[i] ? 2 : 0) + (b[i] ? 1 : 0);
            r[i] = tb[j];
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_bin(logic [63:0] a, logic [63:0] b,
                                            logic [63:0] c, bit half);
        logic [63:0] r;
        int tblv;
        tblv = half ? int'(c[7:4]) : int'(c[3:0]);
        for (int i = 0; i < 64; i++) begin
            int j;
            j = (a[i] ? 2 : 0) + (b[i] ? 1 : 0);
            r[i] = tblv[j];
        end
        return r;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // Compare the outputs with the model, then apply one cycle of stimulus.
    task automatic step(bit v, bit op, logic [63:0] t, logic [63:0] a,
                        logic [63:0] b, logic [63:0] c, logic [7:0] tb,
                        bit half, bit r, bit so, string tag);
        @(negedge clk);
        chk("R5 out_valid", 64'(out_valid), 64'(m_valid));
        chk(m_valid ? m_tag : "R6 hold", result, m_result);
        chk(m_we ? "R7 cr0_we" : "R8 cr0_we", 64'(cr0_we), 64'(m_we));
        chk(m_we ? "R7 cr0" : "R8 cr0", 64'(cr0), 64'(m_cr0));
        in_valid = v; op_sel = op; rt_val = t; ra_val = a; rb_val = b;
        rc_val = c; tbl_imm = tb; nh = half; rec = r; so_in = so;
        m_valid = v;
        m_tag = tag;
        if (v) m_result = op ? ref_bin(a, b, c, half) : ref_tern(t, a, b, tb);
        m_we = v && !op && r;
        if (m_we)
            m_cr0 = {m_result[63], (!m_result[63] && m_result != 0),
                     (m_result == 0), so};
        else
            m_cr0 = 4'b0000;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 out_valid", 64'(out_valid), 64'd0);
        chk("R9 result", result, 64'd0);
        chk("R9 cr0_we", 64'(cr0_we), 64'd0);
        chk("R9 cr0", 64'(cr0), 64'd0);
        rst_n = 1'b1;

        // R2: multiplexer table, with an explicit mux check
        for (int k = 0; k < 16; k++) begin
            logic [63:0] t, a, b;
            t = rnd64(); a = rnd64(); b = rnd64();
            step(1, 0, t, a, b, rnd64(), 8'hD8, 0, 0, 0, "R2 mux");
            @(negedge clk);
            chk("R2 mux explicit", result, (a & b) | (t & ~b));
            in_valid = 1'b0;
            m_valid = 0; m_we = 0; m_cr0 = '0;
        end

        // R1: all 256 immediate tables, back to back (R5)
        for (int k = 0; k < 256; k++)
            step(1, 0, rnd64(), rnd64(), rnd64(), rnd64(), 8'(k), $urandom % 2,
                 $urandom % 2, $urandom % 2, "R1 tern");

        // R3: binary, alternating nibble, with idle gaps
        for (int k = 0; k < 40; k++) begin
            step(1, 1, rnd64(), rnd64(), rnd64(), rnd64(), 8'($urandom), k % 2,
                 $urandom % 2, $urandom % 2, "R3 bin");
            if (k % 5 == 0) step(0, 0, rnd64(), rnd64(), rnd64(), rnd64(), 8'hFF,
                                 0, 1, 1, "R6 idle");
        end

        // R4: binary ignores rt, immediate, rec and upper table bits
        begin
            logic [63:0] a, b, c, fixed;
            a = rnd64(); b = rnd64(); c = 64'h0000_0000_0000_009C;
            fixed = ref_bin(a, b, c, 1);
            for (int k = 0; k < 8; k++) begin
                step(1, 1, rnd64(), a, b, {rnd64() & ~64'hFF} | c, 8'($urandom),
                     1, k % 2, 1, "R4 bin ignore");
                @(negedge clk);
                chk("R4 bin ignore", result, fixed);
                in_valid = 1'b0;
                m_valid = 0; m_we = 0; m_cr0 = '0;
            end
        end

        // R6: idle cycles with moving inputs keep the result
        for (int k = 0; k < 6; k++)
            step(0, k % 2, rnd64(), rnd64(), rnd64(), rnd64(), 8'($urandom),
                 1, 1, 1, "R6 idle");

        // R7: zero, negative and positive results recorded
        step(1, 0, rnd64(), rnd64(), rnd64(), 0, 8'h00, 0, 1, 0, "R7 zero");
        step(1, 0, rnd64(), rnd64(), rnd64(), 0, 8'hFF, 0, 1, 1, "R7 neg");
        step(1, 0, rnd64(), rnd64(), 64'h7FFF_0000_1234_0001, 0, 8'hAA, 0, 1, 0,
             "R7 pos");
        step(1, 0, rnd64(), rnd64(), 64'h0000_0000_0000_0001, 0, 8'hAA, 0, 1, 1,
             "R7 pos so");
        step(1, 0, rnd64(), rnd64(), 64'h8000_0000_0000_0000, 0, 8'hAA, 0, 1, 0,
             "R7 minneg");

        // R8: no record without flag, or for binary operations
        step(1, 0, rnd64(), rnd64(), rnd64(), 0, 8'hFF, 0, 0, 1, "R8 norec");
        step(1, 1, rnd64(), rnd64(), rnd64(), rnd64(), 8'h00, 0, 1, 1, "R8 binrec");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 idle");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 idle");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule